// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces raster video timing in the video transmit clock domain. A pixel counter and a line counter run freely over a programmed frame size. Comparators on those counters mark the horizontal blanking span, the vertical blanking span and the field flag. Two extra one-clock pulses fire at programmed line and pixel positions, for example to start a memory prefetch ahead of active video. The output bus carries these flags, a valid strobe and a constant pixel value. A ready input exists only for bus compatibility and has no effect.

Software programs the block through a small word-addressed register port on its own processor clock. A snapshot of the whole register set crosses into the video domain through a toggle handshake and is held there until the next frame start, so every frame runs with one consistent set. Interlaced timing uses the same datapath: the field flag covers a range of lines, and the vertical blanking window is taken from a second register pair while the field flag is high.

Top module: `vtg_top`

## Requirements
- R1: The pixel counter runs 0 to HTOT-1 and wraps. The line counter advances on each pixel wrap and wraps after VTOT-1. Every output describes the counter position of the previous video clock.
- R2: `out_h` is high when the pixel position x satisfies HSTART <= x < HEND.
- R3: `out_f` is high when the line position y satisfies FSTART <= y < FEND. `out_v` is high when V0START <= y < V0END while the field flag for that line is low, and when V1START <= y < V1END while it is high.
- R4: Each of the two pulse outputs is high for exactly one clock when the counters equal its programmed line and pixel. Bit k of `out_pulse` is pulse k.
- R5: `out_valid` is high exactly when neither `out_h` nor `out_v` is high.
- R6: `out_pix` carries the programmed pixel register value of the active configuration.
- R7: After reset every register reads back its build-time default, all timing outputs are low and `out_pix` equals the default pixel value.
- R8: `out_ready` has no effect. Counting and output continue while it is low.
- R9: While the enable bit (bit 0 of register 0) is clear in the active configuration, both counters are held at zero and all timing flags and pulses are low. When it becomes set, output starts at pixel 0, line 0.
- R10: A new register set takes effect only at a frame boundary, so no frame mixes settings. A burst of writes, each no more than QUIET processor clocks after the previous one, is applied as a single set.
- R11: Register map (word addresses): 0 control, 1 HTOT, 2 VTOT, 3 HSTART, 4 HEND, 5 V0START, 6 V0END, 7 V1START, 8 V1END, 9 FSTART, 10 FEND, 11 pixel value, 12+2k pulse k line, 13+2k pulse k pixel. A read returns, one processor clock after the read strobe, the value last written, truncated to the field width (12 bits for positions, 24 for the pixel, 1 for control).
- R12: Register values reach the video domain only through the handshake. The snapshot in flight stays stable until the video side acknowledges it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor clock |
| cpu_rst | input | 1 | Synchronous active-high reset, processor domain |
| cpu_addr | input | 4 | Register word address |
| cpu_we | input | 1 | Write strobe |
| cpu_wdata | input | 32 | Write data |
| cpu_re | input | 1 | Read strobe |
| cpu_rdata | output | 32 | Read data, valid one clock after the strobe |
| vid_clk | input | 1 | Video transmit clock |
| vid_rst | input | 1 | Synchronous active-high reset, video domain |
| out_ready | input | 1 | Downstream ready, ignored |
| out_valid | output | 1 | Active-picture strobe |
| out_h | output | 1 | Horizontal blanking flag |
| out_v | output | 1 | Vertical blanking flag |
| out_f | output | 1 | Field flag |
| out_pulse | output | 2 | Programmable position pulses |
| out_pix | output | 24 | Constant pixel value |

## Verification
The bench runs a progressive format and an interlaced format whose blanking windows sit at the first pixels, at the last line and across the field change. An off-by-one comparator would shift a flag by one pixel or line, and a field-selection fault would blank the wrong lines in the second field. It changes several registers while video is running and checks that each captured frame matches either the old set or the new set in full. A design that applied settings mid-frame, or in pieces, would produce a hybrid frame. Ready toggles at random throughout, the enable bit is cleared to check that output goes idle, and readback covers defaults and truncation of wide writes.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  parameter int CNT_W     = 12;
  parameter int PIX_W     = 24;
  parameter int NUM_PULSE = 2;
  parameter int RW        = 32;
  localparam int NREG     = 12 + 2 * NUM_PULSE;
  localparam int AW       = $clog2(NREG);

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic                      en;
    cnt_t                      htot;
    cnt_t                      vtot;
    cnt_t                      hs;
    cnt_t                      he;
    cnt_t                      v0s;
    cnt_t                      v0e;
    cnt_t                      v1s;
    cnt_t                      v1e;
    cnt_t                      fs;
    cnt_t                      fe;
    logic [PIX_W-1:0]          pix;
    cnt_t [NUM_PULSE-1:0]      pl;
    cnt_t [NUM_PULSE-1:0]      px;
  } cfg_t;

  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_HTOT  = AW'(1);
  localparam logic [AW-1:0] A_VTOT  = AW'(2);
  localparam logic [AW-1:0] A_HS    = AW'(3);
  localparam logic [AW-1:0] A_HE    = AW'(4);
  localparam logic [AW-1:0] A_V0S   = AW'(5);
  localparam logic [AW-1:0] A_V0E   = AW'(6);
  localparam logic [AW-1:0] A_V1S   = AW'(7);
  localparam logic [AW-1:0] A_V1E   = AW'(8);
  localparam logic [AW-1:0] A_FS    = AW'(9);
  localparam logic [AW-1:0] A_FE    = AW'(10);
  localparam logic [AW-1:0] A_PIX   = AW'(11);
  localparam int            A_PULSE = 12;

  function automatic logic [RW-1:0] get_field(cfg_t c, logic [AW-1:0] a);
    logic [RW-1:0] r;
    r = '0;
    case (a)
      A_CTRL: r[0]           = c.en;
      A_HTOT: r[CNT_W-1:0]   = c.htot;
      A_VTOT: r[CNT_W-1:0]   = c.vtot;
      A_HS:   r[CNT_W-1:0]   = c.hs;
      A_HE:   r[CNT_W-1:0]   = c.he;
      A_V0S:  r[CNT_W-1:0]   = c.v0s;
      A_V0E:  r[CNT_W-1:0]   = c.v0e;
      A_V1S:  r[CNT_W-1:0]   = c.v1s;
      A_V1E:  r[CNT_W-1:0]   = c.v1e;
      A_FS:   r[CNT_W-1:0]   = c.fs;
      A_FE:   r[CNT_W-1:0]   = c.fe;
      A_PIX:  r[PIX_W-1:0]   = c.pix;
      default: ;
    endcase
    for (int k = 0; k < NUM_PULSE; k++) begin
      if (a == AW'(A_PULSE + 2 * k))     r[CNT_W-1:0] = c.pl[k];
      if (a == AW'(A_PULSE + 2 * k + 1)) r[CNT_W-1:0] = c.px[k];
    end
    return r;
  endfunction

  function automatic cfg_t put_field(cfg_t c, logic [AW-1:0] a, logic [RW-1:0] d);
    cfg_t r;
    r = c;
    case (a)
      A_CTRL: r.en   = d[0];
      A_HTOT: r.htot = d[CNT_W-1:0];
      A_VTOT: r.vtot = d[CNT_W-1:0];
      A_HS:   r.hs   = d[CNT_W-1:0];
      A_HE:   r.he   = d[CNT_W-1:0];
      A_V0S:  r.v0s  = d[CNT_W-1:0];
      A_V0E:  r.v0e  = d[CNT_W-1:0];
      A_V1S:  r.v1s  = d[CNT_W-1:0];
      A_V1E:  r.v1e  = d[CNT_W-1:0];
      A_FS:   r.fs   = d[CNT_W-1:0];
      A_FE:   r.fe   = d[CNT_W-1:0];
      A_PIX:  r.pix  = d[PIX_W-1:0];
      default: ;
    endcase
    for (int k = 0; k < NUM_PULSE; k++) begin
      if (a == AW'(A_PULSE + 2 * k))     r.pl[k] = d[CNT_W-1:0];
      if (a == AW'(A_PULSE + 2 * k + 1)) r.px[k] = d[CNT_W-1:0];
    end
    return r;
  endfunction
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter cfg_t DEF   = '0,
  parameter int   QUIET = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [RW-1:0] wdata,
  input  logic          re,
  output logic [RW-1:0] rdata,
  input  logic          ack_tgl,
  output logic          req_tgl,
  output cfg_t          xfer
);
  localparam int QW = $clog2(QUIET + 1);

  cfg_t          shadow;
  logic          dirty;
  logic [QW-1:0] quiet;
  logic          ack_s1, ack_s2;
  logic          busy;

  assign busy = (req_tgl != ack_s2);

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow  <= DEF;
      xfer    <= DEF;
      dirty   <= 1'b0;
      quiet   <= '0;
      req_tgl <= 1'b0;
      ack_s1  <= 1'b0;
      ack_s2  <= 1'b0;
      rdata   <= '0;
    end else begin
      ack_s1 <= ack_tgl;
      ack_s2 <= ack_s1;
      if (we) shadow <= put_field(shadow, addr, wdata);
      if (re) rdata  <= get_field(shadow, addr);
      if (we) quiet <= '0;
      else if (quiet != QW'(QUIET)) quiet <= quiet + 1'b1;
      // launch a snapshot only once the write burst has gone quiet
      if (dirty && !busy && !we && quiet == QW'(QUIET)) begin
        xfer    <= shadow;
        req_tgl <= ~req_tgl;
        dirty   <= 1'b0;
      end
      if (we) dirty <= 1'b1;
    end
  end

  AST_XFER_HELD: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(xfer)); // R12
endmodule

// File: rtl/vtg_cfg_rx.sv
module vtg_cfg_rx
  import vtg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_tgl,
  input  cfg_t xfer,
  output logic ack_tgl,
  output logic new_v,
  output cfg_t new_cfg
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1      <= 1'b0;
      s2      <= 1'b0;
      s3      <= 1'b0;
      ack_tgl <= 1'b0;
      new_v   <= 1'b0;
      new_cfg <= '0;
    end else begin
      s1      <= req_tgl;
      s2      <= s1;
      s3      <= s2;
      ack_tgl <= s3;
      new_v   <= s2 ^ s3;
      if (s2 ^ s3) new_cfg <= xfer;
    end
  end

  AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    new_v |=> !new_v); // R12
endmodule

// File: rtl/vtg_core.sv
module vtg_core
  import vtg_pkg::*;
#(
  parameter cfg_t DEF = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 new_v,
  input  cfg_t                 new_cfg,
  output logic                 o_valid,
  output logic                 o_h,
  output logic                 o_v,
  output logic                 o_f,
  output logic [NUM_PULSE-1:0] o_pulse,
  output logic [PIX_W-1:0]     o_pix
);
  cfg_t cfg, pend_cfg;
  logic pend;
  cnt_t hcnt, vcnt;
  logic line_end, frame_end, load;
  logic in_f, in_v, in_h;

  always_comb begin
    line_end  = hcnt >= cfg.htot - cnt_t'(1);
    frame_end = line_end && (vcnt >= cfg.vtot - cnt_t'(1));
    load      = pend && (!cfg.en || frame_end);
    in_f      = (vcnt >= cfg.fs) && (vcnt < cfg.fe);
    in_v      = in_f ? ((vcnt >= cfg.v1s) && (vcnt < cfg.v1e))
                     : ((vcnt >= cfg.v0s) && (vcnt < cfg.v0e));
    in_h      = (hcnt >= cfg.hs) && (hcnt < cfg.he);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= DEF;
      pend_cfg <= DEF;
      pend     <= 1'b0;
      hcnt     <= '0;
      vcnt     <= '0;
      o_valid  <= 1'b0;
      o_h      <= 1'b0;
      o_v      <= 1'b0;
      o_f      <= 1'b0;
      o_pix    <= DEF.pix;
    end else begin
      if (new_v) begin
        pend_cfg <= new_cfg;
        pend     <= 1'b1;
      end else if (load) begin
        pend     <= 1'b0;
      end
      if (load) cfg <= pend_cfg;

      if (!cfg.en) begin
        hcnt <= '0;
        vcnt <= '0;
      end else if (line_end) begin
        hcnt <= '0;
        vcnt <= frame_end ? '0 : vcnt + cnt_t'(1);
      end else begin
        hcnt <= hcnt + cnt_t'(1);
      end

      o_f     <= cfg.en && in_f;
      o_v     <= cfg.en && in_v;
      o_h     <= cfg.en && in_h;
      o_valid <= cfg.en && !in_h && !in_v;
      o_pix   <= cfg.pix;
    end
  end

  for (genvar k = 0; k < NUM_PULSE; k++) begin : g_pulse
    always_ff @(posedge clk) begin
      if (rst) o_pulse[k] <= 1'b0;
      else     o_pulse[k] <= cfg.en && (hcnt == cfg.px[k]) && (vcnt == cfg.pl[k]);
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      o_pulse[k] && $stable(cfg) && cfg.htot > cnt_t'(1) |=> !o_pulse[k]); // R4
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg.en |=> (hcnt == '0) && (vcnt == '0)); // R9

  AST_CFG_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg) |-> (hcnt == '0) && (vcnt == '0)); // R10

  AST_HCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cfg.en && cfg.htot != '0 && $stable(cfg) |-> hcnt < cfg.htot); // R1

  AST_VALID_BLANK: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> !o_h && !o_v); // R5
endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
#(
  parameter int DEF_HTOT       = 12,
  parameter int DEF_VTOT       = 8,
  parameter int DEF_HS         = 9,
  parameter int DEF_HE         = 12,
  parameter int DEF_V0S        = 6,
  parameter int DEF_V0E        = 8,
  parameter int DEF_V1S        = 6,
  parameter int DEF_V1E        = 8,
  parameter int DEF_FS         = 0,
  parameter int DEF_FE         = 0,
  parameter int DEF_PIX        = 24'h102030,
  parameter int DEF_PULSE_GAP  = 4,
  parameter int QUIET          = 4
) (
  input  logic                 cpu_clk,
  input  logic                 cpu_rst,
  input  logic [AW-1:0]        cpu_addr,
  input  logic                 cpu_we,
  input  logic [RW-1:0]        cpu_wdata,
  input  logic                 cpu_re,
  output logic [RW-1:0]        cpu_rdata,
  input  logic                 vid_clk,
  input  logic                 vid_rst,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic                 out_h,
  output logic                 out_v,
  output logic                 out_f,
  output logic [NUM_PULSE-1:0] out_pulse,
  output logic [PIX_W-1:0]     out_pix
);
  function automatic cfg_t mk_def();
    cfg_t c;
    c.en   = 1'b0;
    c.htot = cnt_t'(DEF_HTOT);
    c.vtot = cnt_t'(DEF_VTOT);
    c.hs   = cnt_t'(DEF_HS);
    c.he   = cnt_t'(DEF_HE);
    c.v0s  = cnt_t'(DEF_V0S);
    c.v0e  = cnt_t'(DEF_V0E);
    c.v1s  = cnt_t'(DEF_V1S);
    c.v1e  = cnt_t'(DEF_V1E);
    c.fs   = cnt_t'(DEF_FS);
    c.fe   = cnt_t'(DEF_FE);
    c.pix  = PIX_W'(DEF_PIX);
    for (int k = 0; k < NUM_PULSE; k++) begin
      c.pl[k] = '0;
      c.px[k] = cnt_t'(k * DEF_PULSE_GAP);
    end
    return c;
  endfunction

  localparam cfg_t DEF_CFG = mk_def();

  logic req_tgl, ack_tgl, new_v;
  cfg_t xfer, new_cfg;
  logic unused_ready;

  assign unused_ready = out_ready;

  vtg_regs #(.DEF(DEF_CFG), .QUIET(QUIET)) regs_i (
    .clk(cpu_clk), .rst(cpu_rst), .addr(cpu_addr), .we(cpu_we),
    .wdata(cpu_wdata), .re(cpu_re), .rdata(cpu_rdata),
    .ack_tgl(ack_tgl), .req_tgl(req_tgl), .xfer(xfer)
  );

  vtg_cfg_rx rx_i (
    .clk(vid_clk), .rst(vid_rst), .req_tgl(req_tgl), .xfer(xfer),
    .ack_tgl(ack_tgl), .new_v(new_v), .new_cfg(new_cfg)
  );

  vtg_core #(.DEF(DEF_CFG)) core_i (
    .clk(vid_clk), .rst(vid_rst), .new_v(new_v), .new_cfg(new_cfg),
    .o_valid(out_valid), .o_h(out_h), .o_v(out_v), .o_f(out_f),
    .o_pulse(out_pulse), .o_pix(out_pix)
  );
endmodule

// File: tb/vtg_top_tb_top.sv
module vtg_top_tb_top;
  localparam int IW = 30;
  typedef logic [IW-1:0] item_t;

  typedef struct {
    int en, htot, vtot, hs, he, v0s, v0e, v1s, v1e, fs, fe, pix;
    int pl0, px0, pl1, px1;
  } bcfg_t;

  logic        cpu_clk = 1'b0, cpu_rst = 1'b1;
  logic        vid_clk = 1'b0, vid_rst = 1'b1;
  logic [3:0]  cpu_addr = '0;
  logic        cpu_we = 1'b0, cpu_re = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        out_ready = 1'b1;
  logic        out_valid, out_h, out_v, out_f;
  logic [1:0]  out_pulse;
  logic [23:0] out_pix;

  int n_vec = 0, n_err = 0, vcycles = 0;
  bit armed = 0, synced = 0;
  item_t q[$];

  always #4 vid_clk = ~vid_clk;
  always #5 cpu_clk = ~cpu_clk;

  vtg_top dut_i (
    .cpu_clk(cpu_clk), .cpu_rst(cpu_rst), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_re(cpu_re), .cpu_rdata(cpu_rdata),
    .vid_clk(vid_clk), .vid_rst(vid_rst), .out_ready(out_ready),
    .out_valid(out_valid), .out_h(out_h), .out_v(out_v), .out_f(out_f),
    .out_pulse(out_pulse), .out_pix(out_pix)
  );

  function automatic item_t exp_item(bcfg_t c, int x, int y);
    bit f, v, h;
    f = (y >= c.fs) && (y < c.fe);
    v = f ? ((y >= c.v1s) && (y < c.v1e)) : ((y >= c.v0s) && (y < c.v0e));
    h = (x >= c.hs) && (x < c.he);
    return {f, v, h, !h && !v, (y == c.pl1 && x == c.px1),
            (y == c.pl0 && x == c.px0), 24'(c.pix)};
  endfunction

  function automatic item_t act_item();
    return {out_f, out_v, out_h, out_valid, out_pulse, out_pix};
  endfunction

  function automatic string tag_of(item_t d);
    if (d[29] || d[28]) return "R3";
    if (d[27])          return "R2";
    if (d[26])          return "R5";
    if (d[25] || d[24]) return "R4";
    return "R6";
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  endtask

  // driver side of the scoreboard
  task automatic expect_frames(bcfg_t c, int n);
    for (int f = 0; f < n; f++)
      for (int y = 0; y < c.vtot; y++)
        for (int x = 0; x < c.htot; x++)
          q.push_back(exp_item(c, x, y));
  endtask

  // monitor: syncs on pulse 0 (programmed at line 0, pixel 0), then one item per clock (R1 order, R8 ready toggling)
  always @(negedge vid_clk) begin
    if (armed) begin
      if (!synced && out_pulse[0]) synced = 1;
      if (synced && q.size() > 0) begin
        item_t e, a;
        e = q.pop_front();
        a = act_item();
        n_vec++;
        if (a !== e) begin
          n_err++;
          $display("FAIL %s raster item: actual %0h expected %0h", tag_of(a ^ e), a, e);
        end
        if (q.size() == 0) begin
          armed  = 0;
          synced = 0;
        end
      end
    end
  end

  // R8: ready wanders randomly, the output must not care
  always @(negedge vid_clk) out_ready <= 1'($urandom);

  always @(posedge vid_clk) begin
    vcycles++;
    if (vcycles > 150000) begin
      n_err++;
      $display("FAIL watchdog: actual %0d expected below %0d", vcycles, 150000);
      finish_up();
    end
  end

  task automatic cpu_burst(int a[$], int d[$]);
    for (int i = 0; i < a.size(); i++) begin
      @(negedge cpu_clk);
      cpu_addr  = 4'(a[i]);
      cpu_wdata = 32'(d[i]);
      cpu_we    = 1'b1;
    end
    @(negedge cpu_clk);
    cpu_we = 1'b0;
  endtask

  task automatic cpu_read(int a, output int d);
    @(negedge cpu_clk);
    cpu_addr = 4'(a);
    cpu_re   = 1'b1;
    @(negedge cpu_clk);
    cpu_re = 1'b0;
    d = int'(cpu_rdata);
  endtask

  task automatic write_cfg(bcfg_t c);
    int a[$], d[$];
    a = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13, 14, 15, 0};
    d = '{c.htot, c.vtot, c.hs, c.he, c.v0s, c.v0e, c.v1s, c.v1e, c.fs, c.fe,
          c.pix, c.pl0, c.px0 | 32'h5A50_0000, c.pl1, c.px1 | 32'hABC0_0000, c.en};
    cpu_burst(a, d);
  endtask

  task automatic vwait(int n);
    repeat (n) @(negedge vid_clk);
  endtask

  task automatic run_frames(bcfg_t c, int n);
    expect_frames(c, n);
    armed = 1;
    wait (!armed);
  endtask

  // R10: each captured frame must equal one configuration entirely
  task automatic frames_ab(bcfg_t ca, bcfg_t cb, int n);
    bit ma, mb;
    @(negedge vid_clk);
    for (int f = 0; f < n; f++) begin
      while (!out_pulse[0]) @(negedge vid_clk);
      ma = 1; mb = 1;
      for (int i = 0; i < ca.htot * ca.vtot; i++) begin
        if (i > 0) @(negedge vid_clk);
        if (act_item() !== exp_item(ca, i % ca.htot, i / ca.htot)) ma = 0;
        if (act_item() !== exp_item(cb, i % cb.htot, i / cb.htot)) mb = 0;
      end
      check(ma || mb, "R10", "frame matches one whole set", int'(ma) * 2 + int'(mb), 1);
      if (f == n - 1) check(mb, "R10", "last frame uses new set", int'(mb), 1);
      @(negedge vid_clk);
    end
  endtask

  initial begin
    bcfg_t p, il, il2, off;
    int rd, bad;
    p   = '{1, 12, 8, 9, 12, 6, 8, 6, 8, 0, 0, 'hABCDEF, 0, 0, 3, 3};
    il  = '{1, 12, 10, 0, 2, 0, 1, 5, 7, 5, 10, 'h00FF00, 0, 0, 9, 11};
    il2 = '{1, 12, 10, 4, 7, 0, 1, 6, 8, 5, 10, 'h0F0F0F, 0, 0, 7, 2};

    repeat (4) @(negedge cpu_clk);
    cpu_rst = 1'b0;
    vid_rst = 1'b0;
    vwait(3);

    // R7 reset state and defaults
    check({out_valid, out_h, out_v, out_f, out_pulse} == 6'b0, "R7", "flags after reset",
          {out_valid, out_h, out_v, out_f, out_pulse}, 0);
    check(out_pix == 24'h102030, "R7", "default pixel", out_pix, 'h102030);
    cpu_read(1, rd);  check(rd == 12, "R7", "default HTOT", rd, 12);
    cpu_read(0, rd);  check(rd == 0, "R7", "default control", rd, 0);
    cpu_read(15, rd); check(rd == 4, "R7", "default pulse1 pixel", rd, 4);
    cpu_read(11, rd); check(rd == 'h102030, "R7", "default pixel reg", rd, 'h102030);

    // R9: disabled at reset, nothing moves
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge vid_clk);
      if ({out_valid, out_h, out_v, out_f, out_pulse} != 6'b0) bad++;
    end
    check(bad == 0, "R9", "idle while disabled", bad, 0);

    // progressive format, R12 crossing, R1 R2 R5 R6
    write_cfg(p);
    cpu_read(15, rd); check(rd == 3, "R11", "pulse1 pixel truncated", rd, 3);
    cpu_read(11, rd); check(rd == 'hABCDEF, "R11", "pixel readback", rd, 'hABCDEF);
    cpu_read(0, rd);  check(rd == 1, "R11", "control readback", rd, 1);
    run_frames(p, 2);

    // interlaced format written while running: R3 R4 R12
    write_cfg(il);
    vwait(300);
    run_frames(il, 3);

    // mid-run change must land on a frame boundary as a whole: R10
    write_cfg(il2);
    frames_ab(il, il2, 4);
    run_frames(il2, 1);

    // R9: clear enable, output goes idle
    off = il2;
    off.en = 0;
    cpu_burst('{0}, '{0});
    vwait(300);
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge vid_clk);
      if ({out_valid, out_h, out_v, out_f, out_pulse} != 6'b0) bad++;
    end
    check(bad == 0, "R9", "idle after disable", bad, 0);
    check(out_pix == 24'(off.pix), "R6", "pixel held while idle", out_pix, off.pix);

    // R9: re-enable starts from line 0 pixel 0
    write_cfg(p);
    run_frames(p, 1);

    finish_up();
  end
endmodule